// File: doc/BRIEF.md
# Delayed Transmit Burst Generator for One Beamformer Channel

This block drives one transmit channel of an ultrasound beamformer. It holds a burst pattern of two-bit drive symbols and a table of delay words. On a fire command with an event index, it looks up that event's delay and waits out the coarse part on a half-rate tick. It then reads the pattern and pushes it out as parallel words, `LANES` symbols per word clock, to an external serializer that runs `LANES` times faster. Whole word-clock steps and sub-word symbol steps of the delay are added on the way out. The total delay therefore has the resolution of one serial symbol, about 2 ns at a 120 MHz word clock.

Each output symbol is a positive-drive enable and a negative-drive enable. A symbol with both enables set is turned into "off" before it leaves, so the two rails are never switched on together. The two table write ports use a valid/ready handshake. `ready` is high only while the channel is idle. While a burst runs, `ready` stays low, so a write is held off and nothing is changed. The output words have no handshake, because the serializer takes one word on every clock and cannot apply back-pressure. Fire, length and status are plain pins.

Top module: `tx_chan_pulsegen`

## Requirements
- R1: After reset every drive output is off, `busy`, `done` and `fire_err` are low, and both write ports show ready.
- R2: A fire selects the delay-table entry at `fire_idx`. An entry holds the sub-word offset S in bits [1:0], the whole-cycle step N in bit [2] and the coarse count C in bits [10:3]. Its delay is D = 8·C + 4·N + S serial slots, with each coarse unit lasting two word clocks.
- R3: Number the word-clock cycles from 0, where cycle 0 follows the edge that samples `fire`. Slot 4·n + i is lane i of the output in cycle n. Pattern symbol j appears at slot 16 + D + j.
- R4: A pattern word holds symbol k of that word in bits [2k+1:2k], with bit 2k the positive enable and bit 2k+1 the negative enable. Lower k comes earlier in time. The value in `len_m1`, latched by a fire, makes the burst exactly `len_m1`+1 words long. Every slot outside the burst is off.
- R5: A pattern symbol with both enables set is driven as off.
- R6: `busy` is high from cycle 0 through cycle 2·C + L + 5, where L is the number of words. `done` is a one-cycle pulse in cycle 2·C + L + 6, and `busy` is low in that cycle.
- R7: A fire that arrives while `busy` is high has no effect on the running burst. It sets `fire_err`, which then stays high until reset.
- R8: Each write port accepts on valid and ready together, and ready is high only while idle. A write that is offered during a burst does not change the stored pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_valid | input | 1 | Pattern write offered |
| pw_ready | output | 1 | Pattern write accepted (idle) |
| pw_addr | input | 8 | Pattern word address |
| pw_data | input | 8 | Pattern word, four symbols |
| dw_valid | input | 1 | Delay entry write offered |
| dw_ready | output | 1 | Delay entry write accepted (idle) |
| dw_addr | input | 10 | Delay table index |
| dw_data | input | 11 | Delay word {C, N, S} |
| len_we | input | 1 | Load burst length register |
| len_m1 | input | 8 | Burst length in words minus one |
| fire | input | 1 | Start a transmit event |
| fire_idx | input | 10 | Delay table index for this event |
| drv_pos | output | 4 | Positive drive enables, lane 0 earliest |
| drv_neg | output | 4 | Negative drive enables, lane 0 earliest |
| busy | output | 1 | Event in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| fire_err | output | 1 | Sticky fire-while-busy flag |

## Verification
The table entries 0 to 63 hold delay words equal to their own index. Firing each of them therefore steps D through every value from 0 to 63. This sweep separates mistakes in each of the three delay fields and in their weights, because each field acts on a different bit of D. The sweep is run with burst lengths of 1 to 6 words over a pattern that contains all four symbol codes, which exposes symbol-order, lane and spill-over errors at word boundaries. A maximal delay word at the top table index, a full-length burst, an all-both-on pattern, and a fire and a write injected in the middle of a burst probe the edges of the index range, the length register, the off-forcing rule and the busy rules.

// File: rtl/txpg_pkg.sv
`timescale 1ns/1ps
package txpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COARSE,
    ST_STREAM,
    ST_DRAIN
  } txpg_state_e;

  // both rails requested -> drive nothing
  function automatic logic [1:0] safe_sym(input logic [1:0] s);
    return (s == 2'b11) ? 2'b00 : s;
  endfunction
endpackage

// File: rtl/tx_delay_tbl.sv
`timescale 1ns/1ps
module tx_delay_tbl #(
  parameter int ENTRIES = 1024,
  parameter int IDX_W   = 10,
  parameter int DLY_W   = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DLY_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DLY_W-1:0] rdata
);
  logic [DLY_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tx_pat_store.sv
`timescale 1ns/1ps
module tx_pat_store #(
  parameter int WORDS  = 256,
  parameter int AW     = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end
endmodule

// File: rtl/tx_word_shift.sv
`timescale 1ns/1ps
module tx_word_shift
  import txpg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SUB_W = 2,
  parameter int CYC_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LANES-1:0] in_word,
  input  logic               in_valid,
  input  logic [CYC_W-1:0]   cyc_sel,
  input  logic [SUB_W-1:0]   sub_sel,
  output logic [LANES-1:0]   drv_pos,
  output logic [LANES-1:0]   drv_neg
);
  localparam int WORD_W = 2 * LANES;
  localparam int TAPS   = 1 << CYC_W;

  logic [WORD_W-1:0] taps [TAPS];
  logic [WORD_W-1:0] sel_w;
  logic [WORD_W-1:0] prev_q;
  logic [1:0]        seq [2*LANES];
  logic [LANES-1:0]  pos_d, neg_d;

  // invalid cycles enter the line as all-off words
  assign taps[0] = in_valid ? in_word : '0;

  // whole word-clock delay line
  for (genvar k = 1; k < TAPS; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[k] <= '0;
      else        taps[k] <= taps[k-1];
    end
  end

  assign sel_w = taps[cyc_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sel_w;
  end

  // sub-word symbol shift across the previous/current word pair
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      seq[i]         = prev_q[2*i +: 2];
      seq[LANES + i] = sel_w[2*i +: 2];
    end
    for (int i = 0; i < LANES; i++) begin
      logic [1:0] s;
      s = safe_sym(seq[LANES + i - int'(sub_sel)]);
      pos_d[i] = s[0];
      neg_d[i] = s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_pos <= '0;
      drv_neg <= '0;
    end else begin
      drv_pos <= pos_d;
      drv_neg <= neg_d;
    end
  end

  // R5: registered outputs never enable both rails of a lane
  p_no_both_rails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_pos & drv_neg) == '0);
endmodule

// File: rtl/tx_chan_pulsegen.sv
`timescale 1ns/1ps
module tx_chan_pulsegen
  import txpg_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int PAT_BITS    = 2048,
  parameter int DLY_ENTRIES = 1024,
  parameter int COARSE_W    = 8,
  parameter int CYC_W       = 1,
  parameter int WORD_W      = 2 * LANES,
  parameter int PA_W        = $clog2(PAT_BITS / (2 * LANES)),
  parameter int DI_W        = $clog2(DLY_ENTRIES),
  parameter int SUB_W       = $clog2(LANES),
  parameter int DLY_W       = COARSE_W + CYC_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_valid,
  output logic              pw_ready,
  input  logic [PA_W-1:0]   pw_addr,
  input  logic [WORD_W-1:0] pw_data,
  input  logic              dw_valid,
  output logic              dw_ready,
  input  logic [DI_W-1:0]   dw_addr,
  input  logic [DLY_W-1:0]  dw_data,
  input  logic              len_we,
  input  logic [PA_W-1:0]   len_m1,
  input  logic              fire,
  input  logic [DI_W-1:0]   fire_idx,
  output logic [LANES-1:0]  drv_pos,
  output logic [LANES-1:0]  drv_neg,
  output logic              busy,
  output logic              done,
  output logic              fire_err
);
  localparam int PAT_WORDS  = PAT_BITS / WORD_W;
  localparam int CYC_MAX    = (1 << CYC_W) - 1;
  localparam int DC_W       = CYC_W + 2;
  localparam int DRAIN_LAST = CYC_MAX + 2;

  txpg_state_e         state;
  logic [DLY_W-1:0]    dly_rd;
  logic [PA_W-1:0]     len_reg, len_q, wa;
  logic [COARSE_W-1:0] cnt;
  logic                ph;
  logic [CYC_W-1:0]    cyc_q;
  logic [SUB_W-1:0]    sub_q;
  logic [DC_W-1:0]     dcnt;
  logic [WORD_W-1:0]   pat_rd;
  logic                pat_rv;
  logic                idle;

  assign idle     = (state == ST_IDLE);
  assign busy     = !idle;
  assign pw_ready = idle;
  assign dw_ready = idle;

  tx_delay_tbl #(.ENTRIES(DLY_ENTRIES), .IDX_W(DI_W), .DLY_W(DLY_W)) u_dly (
    .clk   (clk),
    .we    (dw_valid && dw_ready),
    .waddr (dw_addr),
    .wdata (dw_data),
    .raddr (fire_idx),
    .rdata (dly_rd)
  );

  tx_pat_store #(.WORDS(PAT_WORDS), .AW(PA_W), .WORD_W(WORD_W)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (pw_valid && pw_ready),
    .waddr  (pw_addr),
    .wdata  (pw_data),
    .rd_en  (state == ST_STREAM),
    .raddr  (wa),
    .rdata  (pat_rd),
    .rvalid (pat_rv)
  );

  tx_word_shift #(.LANES(LANES), .SUB_W(SUB_W), .CYC_W(CYC_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_word  (pat_rd),
    .in_valid (pat_rv),
    .cyc_sel  (cyc_q),
    .sub_sel  (sub_q),
    .drv_pos  (drv_pos),
    .drv_neg  (drv_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_reg <= '0;
    else if (len_we) len_reg <= len_m1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      wa       <= '0;
      cnt      <= '0;
      ph       <= 1'b0;
      cyc_q    <= '0;
      sub_q    <= '0;
      dcnt     <= '0;
      done     <= 1'b0;
      fire_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fire && !idle) fire_err <= 1'b1;
      unique case (state)
        ST_IDLE: if (fire) begin
          state <= ST_LOAD;
          len_q <= len_reg;
        end
        ST_LOAD: begin
          cnt   <= dly_rd[DLY_W-1 -: COARSE_W];
          cyc_q <= dly_rd[SUB_W +: CYC_W];
          sub_q <= dly_rd[SUB_W-1:0];
          ph    <= 1'b0;
          state <= ST_COARSE;
        end
        ST_COARSE: begin
          if (cnt == '0) begin
            state <= ST_STREAM;
            wa    <= '0;
          end else begin
            ph <= !ph;
            if (ph) cnt <= cnt - 1'b1;
          end
        end
        ST_STREAM: begin
          if (wa == len_q) begin
            state <= ST_DRAIN;
            dcnt  <= '0;
          end else begin
            wa <= wa + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (dcnt == DC_W'(DRAIN_LAST)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the coarse counter only moves downward while waiting
  p_coarse_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COARSE && $past(state) == ST_COARSE) |-> (cnt <= $past(cnt)));

  // R4: readout address stays inside the latched burst length
  p_addr_in_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM) |-> (wa <= len_q));

  // R4: nothing is driven while the channel is idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (drv_pos == '0 && drv_neg == '0));

  // R6: done is a single pulse that follows the drain phase
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == ST_DRAIN && idle));

  // R7: a fire during a burst never restarts it, and the flag holds
  p_busy_fire_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |=> (state != ST_LOAD));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_err |=> fire_err);
endmodule

// File: tb/tx_chan_pulsegen_tb_top.sv
`timescale 1ns/1ps
module tx_chan_pulsegen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pw_valid = 1'b0, dw_valid = 1'b0, len_we = 1'b0, fire = 1'b0;
  logic       pw_ready, dw_ready;
  logic [7:0] pw_addr = '0, pw_data = '0, len_m1 = '0;
  logic [9:0] dw_addr = '0, fire_idx = '0;
  logic [10:0] dw_data = '0;
  logic [3:0] drv_pos, drv_neg;
  logic       busy, done, fire_err;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  logic [7:0]  pm [256];
  logic [10:0] dm [1024];

  always #4 clk = !clk;

  tx_chan_pulsegen dut_i (
    .clk(clk), .rst_n(rst_n),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_addr(pw_addr), .pw_data(pw_data),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_addr(dw_addr), .dw_data(dw_data),
    .len_we(len_we), .len_m1(len_m1), .fire(fire), .fire_idx(fire_idx),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .busy(busy), .done(done), .fire_err(fire_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr_pat(input int a, input logic [7:0] d);
    @(negedge clk);
    pw_valid = 1'b1; pw_addr = 8'(a); pw_data = d;
    @(negedge clk);
    pw_valid = 1'b0;
    pm[a] = d;
  endtask

  task automatic wr_dly(input int a, input logic [10:0] d);
    @(negedge clk);
    dw_valid = 1'b1; dw_addr = 10'(a); dw_data = d;
    @(negedge clk);
    dw_valid = 1'b0;
    dm[a] = d;
  endtask

  // expected {neg,pos} in slot p for a burst with delay d and length l
  function automatic logic [1:0] exp_sym(input int p, input int d, input int l);
    int j;
    logic [1:0] s;
    j = p - 16 - d;
    if (j < 0 || j >= 4 * l) return 2'b00;
    s = pm[j / 4][2 * (j % 4) +: 2];
    return (s == 2'b11) ? 2'b00 : s;
  endfunction

  // mode 0 plain, 1 inject write during burst, 2 inject fire during burst
  task automatic run_burst(input int idx, input int l, input int mode, input string tag);
    int c, d, dc;
    bit s_ok, t_ok;
    int s_act, s_exp, t_act, t_exp;
    c  = int'(dm[idx][10:3]);
    d  = 8 * c + 4 * int'(dm[idx][2]) + int'(dm[idx][1:0]);
    dc = 2 * c + l + 6;
    s_ok = 1'b1; t_ok = 1'b1;
    s_act = 0; s_exp = 0; t_act = 0; t_exp = 0;
    @(negedge clk);
    len_we = 1'b1; len_m1 = 8'(l - 1);
    @(negedge clk);
    len_we = 1'b0;
    fire = 1'b1; fire_idx = 10'(idx);
    @(posedge clk);
    @(negedge clk);
    fire = 1'b0;
    for (int n = 0; n <= dc + 3; n++) begin
      for (int i = 0; i < 4; i++) begin
        logic [1:0] e;
        e = exp_sym(4 * n + i, d, l);
        if (s_ok && ({drv_neg[i], drv_pos[i]} != e)) begin
          s_ok = 1'b0;
          s_act = int'({drv_neg[i], drv_pos[i]});
          s_exp = int'(e);
          $display("  slot %0d mismatch in burst idx %0d", 4 * n + i, idx);
        end
      end
      if (t_ok && ((busy != (n < dc)) || (done != (n == dc)))) begin
        t_ok = 1'b0;
        t_act = n;
        t_exp = dc;
      end
      if (n == 2 && mode == 1) begin
        chk(pw_ready == 1'b0, "R8", "pattern ready during burst", int'(pw_ready), 0);
        pw_valid = 1'b1; pw_addr = 8'd0; pw_data = ~pm[0];
      end
      if (n == 2 && mode == 2) begin
        fire = 1'b1; fire_idx = 10'(idx ^ 1);
      end
      if (n == 3) begin
        pw_valid = 1'b0;
        fire = 1'b0;
      end
      @(negedge clk);
    end
    chk(s_ok, tag, "output symbol stream", s_act, s_exp);
    chk(t_ok, "R6", "busy/done timing (cycle of first mismatch)", t_act, t_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) dm[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(drv_pos == 4'h0 && drv_neg == 4'h0, "R1", "drive outputs", int'({drv_neg, drv_pos}), 0);
    chk(!busy && !done && !fire_err, "R1", "status flags", int'({busy, done, fire_err}), 0);
    chk(pw_ready && dw_ready, "R1", "write readies", int'({pw_ready, dw_ready}), 3);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 256; w++) wr_pat(w, 8'((w * 29 + 7) ^ (w >> 3)));
    for (int k = 0; k < 64; k++) wr_dly(k, 11'(k));
    wr_dly(1023, 11'h7FF);

    // R2 R3 R4: every delay 0..63 with burst lengths 1..6
    for (int k = 0; k < 64; k++) run_burst(k, (k % 6) + 1, 0, "R2 R3 R4 delay sweep");
    // R2 R4: top table index, largest delay word, full-length pattern
    run_burst(1023, 256, 0, "R2 R4 max delay full length");

    // R8: write offered mid-burst, then the stored word must be unchanged
    run_burst(9, 3, 1, "R3 burst with held-off write");
    run_burst(9, 3, 0, "R8 pattern unchanged after held-off write");

    // R7: fire mid-burst is ignored and raises the sticky flag
    chk(fire_err == 1'b0, "R7", "flag before stray fire", int'(fire_err), 0);
    run_burst(20, 2, 2, "R7 burst with stray fire");
    chk(fire_err == 1'b1, "R7", "flag after stray fire", int'(fire_err), 1);
    run_burst(13, 4, 0, "R7 clean burst after stray fire");
    chk(fire_err == 1'b1, "R7", "flag stays set", int'(fire_err), 1);

    // R5: all-both-on words come out as off
    for (int w = 0; w < 4; w++) wr_pat(w, 8'hFF);
    run_burst(6, 4, 0, "R5 both-on forced off");
    run_burst(3, 5, 0, "R5 mixed both-on and drive");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule